// File: doc/BRIEF.md
# Drift-compensated nanosecond time counter

This block keeps a 64-bit time value in nanoseconds. While running, it adds a programmable base increment on every reference clock tick. A clock source that runs slightly fast or slow is trimmed by sometimes adding an alternate increment in place of the base one. Two mechanisms choose when the alternate increment is used. A burst counter applies it on each of the next N ticks. An interval counter applies it once every N ticks, without end, which gives continuous fine frequency correction.

Software reaches the block through a simple word-wide register port. It can start and stop counting, set both increments, arm either trim mechanism, load a new time, read the time coherently as two words, and clear a sticky wrap flag. A neighbouring compare unit can pulse `cnt_clear` to restart the time at zero, for example at the end of each fixed cycle.

A two-state run controller governs counting. In state HALT the time and both trim counters hold their values. In state RUN every tick advances them. A CTRL write with bit 0 set moves HALT to RUN, and a CTRL write with bit 0 clear moves RUN to HALT. Any other write leaves the state as it is.

Top module: `ntc_time_counter`

## Requirements
- R1: After reset the time is 0, the wrap flag is 0, the controller is in HALT, and every register reads 0. Word addresses are CTRL=0, STATUS=1, BURST=2, INTERVAL=3, TIME_LO=4 and TIME_HI=5; any other address reads 0.
- R2: CTRL bit 0 is the run enable, bits 7:4 are the base increment and bits 19:8 are the alternate increment. In RUN with no trim active, the time grows by the base increment on every clock edge. The first increment happens on the edge after the CTRL write.
- R3: In HALT, the time, the BURST count and the interval down-counter all hold their values.
- R4: While the BURST count (24 bits) is non-zero in RUN, each tick adds the alternate increment and lowers the count by one. Writing 0 stops the burst.
- R5: Writing N≠0 to INTERVAL makes the alternate increment apply once every N running ticks, first on the N-th tick after the write. N=0 turns this trim off, and INTERVAL reads back N.
- R6: A TIME_HI write goes to a holding word. A later TIME_LO write loads the time with {holding word, written low word}, and this load replaces that edge's increment.
- R7: A read returns data on `reg_rdata` one cycle after `reg_rd`. A TIME_LO read captures the high half of the same time value, and the next TIME_HI read returns that captured half.
- R8: When an increment carries out of bit 63, STATUS bit 0 sets on the same edge that the time wraps, and counting continues. Writing 1 to STATUS bit 0 clears the flag, but a new wrap on the same edge wins.
- R9: A `cnt_clear` pulse forces the time to 0 on the next edge. It has priority over both the increment and a TIME_LO load, while the trim counters keep running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one tick per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| cnt_clear | input | 1 | Restart time at zero on the next edge |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| time_now | output | 64 | Current time value |
| ovf_flag | output | 1 | Sticky wrap flag |

## Verification
Directed runs use the base increment alone, a short burst, and a short interval. Each of these gives a different increment sequence per tick, so a swapped increment field or an off-by-one interval shows up as a wrong time. Loading a time just below all-ones separates the wrap edge from the flag edge. A clear pulse issued during a burst shows whether the trim counters kept running. Seeded random sequences mix all register operations with halts and clears, and catch priority errors between load, clear and increment.

// File: rtl/ntc_pkg.sv
package ntc_pkg;
    typedef enum logic {ST_HALT = 1'b0, ST_RUN = 1'b1} run_state_t;

    localparam int ADR_CTRL     = 0;
    localparam int ADR_STATUS   = 1;
    localparam int ADR_BURST    = 2;
    localparam int ADR_INTERVAL = 3;
    localparam int ADR_TIME_LO  = 4;
    localparam int ADR_TIME_HI  = 5;

    localparam int EN_BIT   = 0;
    localparam int BASE_LSB = 4;
    localparam int ALT_LSB  = 8;
endpackage

// File: rtl/ntc_regs.sv
module ntc_regs
    import ntc_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 3,
    parameter int BASE_W = 4,
    parameter int ALT_W  = 12,
    parameter int BURST_W = 24,
    parameter int CNT_W  = 2 * WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic               rd,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [WORD_W-1:0]  wdata,
    input  logic [CNT_W-1:0]   cnt_now,
    input  logic               ovf_now,
    input  logic [BURST_W-1:0] burst_now,
    output logic               run_en,
    output logic [BASE_W-1:0]  base_inc,
    output logic [ALT_W-1:0]   alt_inc,
    output logic [WORD_W-1:0]  ival,
    output logic               ld_burst,
    output logic               ld_ival,
    output logic               ld_time,
    output logic [CNT_W-1:0]   ld_val,
    output logic               ovf_wc,
    output logic [WORD_W-1:0]  rdata
);
    localparam int HALF_W = CNT_W / 2;

    run_state_t            state_q, state_d;
    logic [HALF_W-1:0]     hi_pend, hi_snap;
    logic                  wr_ctrl, wr_hi;

    always_comb begin
        wr_ctrl  = wr && (addr == ADDR_W'(ADR_CTRL));
        wr_hi    = wr && (addr == ADDR_W'(ADR_TIME_HI));
        ld_burst = wr && (addr == ADDR_W'(ADR_BURST));
        ld_ival  = wr && (addr == ADDR_W'(ADR_INTERVAL));
        ld_time  = wr && (addr == ADDR_W'(ADR_TIME_LO));
        ovf_wc   = wr && (addr == ADDR_W'(ADR_STATUS)) && wdata[0];
        ld_val   = {hi_pend, wdata[HALF_W-1:0]};
    end

    // run controller: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (wr_ctrl && wdata[EN_BIT])  state_d = ST_RUN;
            ST_RUN:  if (wr_ctrl && !wdata[EN_BIT]) state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // run controller: outputs
    always_comb begin
        unique case (state_q)
            ST_RUN:  run_en = 1'b1;
            default: run_en = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_inc <= '0;
            alt_inc  <= '0;
            ival     <= '0;
            hi_pend  <= '0;
        end else begin
            if (wr_ctrl) begin
                base_inc <= wdata[BASE_LSB +: BASE_W];
                alt_inc  <= wdata[ALT_LSB +: ALT_W];
            end
            if (ld_ival) ival    <= wdata;
            if (wr_hi)   hi_pend <= wdata[HALF_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata   <= '0;
            hi_snap <= '0;
        end else if (rd) begin
            rdata <= '0;
            case (addr)
                ADDR_W'(ADR_CTRL): begin
                    rdata[EN_BIT]              <= state_q == ST_RUN;
                    rdata[BASE_LSB +: BASE_W]  <= base_inc;
                    rdata[ALT_LSB +: ALT_W]    <= alt_inc;
                end
                ADDR_W'(ADR_STATUS):   rdata[0] <= ovf_now;
                ADDR_W'(ADR_BURST):    rdata[BURST_W-1:0] <= burst_now;
                ADDR_W'(ADR_INTERVAL): rdata <= ival;
                ADDR_W'(ADR_TIME_LO): begin
                    rdata   <= WORD_W'(cnt_now[HALF_W-1:0]);
                    hi_snap <= cnt_now[CNT_W-1:HALF_W];
                end
                ADDR_W'(ADR_TIME_HI):  rdata <= WORD_W'(hi_snap);
                default:               rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/ntc_rate.sv
module ntc_rate #(
    parameter int BURST_W = 24,
    parameter int IVAL_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic               ld_burst,
    input  logic [BURST_W-1:0] burst_wdata,
    input  logic               ld_ival,
    input  logic [IVAL_W-1:0]  ival_wdata,
    input  logic [IVAL_W-1:0]  ival,
    output logic [BURST_W-1:0] burst_cnt,
    output logic               use_alt
);
    logic [IVAL_W-1:0] slow_q;
    logic              burst_live, slow_fire;

    always_comb begin
        burst_live = burst_cnt != '0;
        slow_fire  = (ival != '0) && (slow_q == '0);
        use_alt    = run_en && (burst_live || slow_fire);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_cnt <= '0;
        end else if (ld_burst) begin
            burst_cnt <= burst_wdata;
        end else if (run_en && burst_live) begin
            burst_cnt <= burst_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slow_q <= '0;
        end else if (ld_ival) begin
            slow_q <= (ival_wdata == '0) ? '0 : ival_wdata - 1'b1;
        end else if (run_en && ival != '0) begin
            slow_q <= (slow_q == '0) ? ival - 1'b1 : slow_q - 1'b1;
        end
    end
endmodule

// File: rtl/ntc_accum.sv
module ntc_accum #(
    parameter int CNT_W = 64,
    parameter int INC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [INC_W-1:0] inc,
    input  logic             clr,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             ovf_wc,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    logic [CNT_W:0] sum;
    logic           wrap;

    always_comb begin
        sum  = {1'b0, cnt} + (CNT_W+1)'(inc);
        wrap = run_en && !clr && !ld && sum[CNT_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (clr)    cnt <= '0;
        else if (ld)     cnt <= ld_val;
        else if (run_en) cnt <= sum[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      ovf <= 1'b0;
        else if (wrap)   ovf <= 1'b1;
        else if (ovf_wc) ovf <= 1'b0;
    end
endmodule

// File: rtl/ntc_time_counter.sv
module ntc_time_counter #(
    parameter int WORD_W  = 32,
    parameter int ADDR_W  = 3,
    parameter int BASE_W  = 4,
    parameter int ALT_W   = 12,
    parameter int BURST_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              cnt_clear,
    output logic [WORD_W-1:0] reg_rdata,
    output logic [2*WORD_W-1:0] time_now,
    output logic              ovf_flag
);
    localparam int CNT_W = 2 * WORD_W;

    logic               run_en, use_alt;
    logic [BASE_W-1:0]  base_inc;
    logic [ALT_W-1:0]   alt_inc, inc_sel;
    logic [WORD_W-1:0]  ival;
    logic               ld_burst, ld_ival, ld_time, ovf_wc;
    logic [CNT_W-1:0]   ld_val;
    logic [BURST_W-1:0] burst_cnt;

    ntc_regs #(
        .WORD_W(WORD_W), .ADDR_W(ADDR_W), .BASE_W(BASE_W),
        .ALT_W(ALT_W), .BURST_W(BURST_W), .CNT_W(CNT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd),
        .addr(reg_addr), .wdata(reg_wdata), .cnt_now(time_now),
        .ovf_now(ovf_flag), .burst_now(burst_cnt), .run_en(run_en),
        .base_inc(base_inc), .alt_inc(alt_inc), .ival(ival),
        .ld_burst(ld_burst), .ld_ival(ld_ival), .ld_time(ld_time),
        .ld_val(ld_val), .ovf_wc(ovf_wc), .rdata(reg_rdata)
    );

    ntc_rate #(.BURST_W(BURST_W), .IVAL_W(WORD_W)) u_rate (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .ld_burst(ld_burst), .burst_wdata(reg_wdata[BURST_W-1:0]),
        .ld_ival(ld_ival), .ival_wdata(reg_wdata), .ival(ival),
        .burst_cnt(burst_cnt), .use_alt(use_alt)
    );

    always_comb inc_sel = use_alt ? alt_inc : ALT_W'(base_inc);

    ntc_accum #(.CNT_W(CNT_W), .INC_W(ALT_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .inc(inc_sel),
        .clr(cnt_clear), .ld(ld_time), .ld_val(ld_val), .ovf_wc(ovf_wc),
        .cnt(time_now), .ovf(ovf_flag)
    );
endmodule

// File: rtl/ntc_checker.sv
module ntc_checker #(
    parameter int ADDR_W = 3,
    parameter int BASE_W = 4,
    parameter int ALT_W  = 12,
    parameter int CNT_W  = 64,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              wbit0,
    input logic              cnt_clear,
    input logic [WORD_W-1:0] reg_rdata,
    input logic [CNT_W-1:0]  time_now,
    input logic              ovf_flag,
    input logic              run_en,
    input logic [BASE_W-1:0] base_inc,
    input logic [ALT_W-1:0]  alt_inc
);
    import ntc_pkg::*;

    logic lo_wr, st_wc, lo_rd;
    always_comb begin
        lo_wr = reg_wr && reg_addr == ADDR_W'(ADR_TIME_LO);
        st_wc = reg_wr && reg_addr == ADDR_W'(ADR_STATUS) && wbit0;
        lo_rd = reg_rd && reg_addr == ADDR_W'(ADR_TIME_LO);
    end

    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clear |=> time_now == '0);

    assert_halt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !cnt_clear && !lo_wr) |=> $stable(time_now));

    assert_step_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !cnt_clear && !lo_wr) |=>
            ((time_now - $past(time_now)) == CNT_W'($past(base_inc))) ||
            ((time_now - $past(time_now)) == CNT_W'($past(alt_inc))));

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !st_wc) |=> ovf_flag);

    assert_lo_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lo_rd |=> reg_rdata == WORD_W'($past(time_now[CNT_W/2-1:0])));
endmodule

bind ntc_time_counter ntc_checker #(
    .ADDR_W(ADDR_W), .BASE_W(BASE_W), .ALT_W(ALT_W),
    .CNT_W(2*WORD_W), .WORD_W(WORD_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .wbit0(reg_wdata[0]), .cnt_clear(cnt_clear),
    .reg_rdata(reg_rdata), .time_now(time_now), .ovf_flag(ovf_flag),
    .run_en(run_en), .base_inc(base_inc), .alt_inc(alt_inc)
);

// File: tb/sim_ntc_time_counter.sv
module sim_ntc_time_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, cnt_clear = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] time_now;
    logic        ovf_flag;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // expected state
    bit          m_en, m_ovf;
    logic [3:0]  m_base;
    logic [11:0] m_alt;
    logic [23:0] m_burst;
    logic [31:0] m_ival, m_slow, m_hipend, m_hisnap, m_rdata;
    logic [63:0] m_cnt;

    always #4 clk = ~clk;

    ntc_time_counter u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .cnt_clear(cnt_clear),
        .reg_rdata(reg_rdata), .time_now(time_now), .ovf_flag(ovf_flag)
    );

    task automatic chk64(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] read_val(logic [2:0] a);
        case (a)
            3'd0: return {12'b0, m_alt, m_base, 3'b0, m_en};
            3'd1: return {31'b0, m_ovf};
            3'd2: return {8'b0, m_burst};
            3'd3: return m_ival;
            3'd4: return m_cnt[31:0];
            3'd5: return m_hisnap;
            default: return 32'h0;
        endcase
    endfunction

    function automatic void model(bit w, bit r, logic [2:0] a, logic [31:0] d, bit c);
        bit          alt;
        logic [64:0] sum;
        alt = m_en && (m_burst != 0 || (m_ival != 0 && m_slow == 0));
        sum = {1'b0, m_cnt} + 65'(alt ? m_alt : {8'b0, m_base});
        if (r) begin
            m_rdata = read_val(a);
            if (a == 3'd4) m_hisnap = m_cnt[63:32];
        end
        if (!c && !(w && a == 3'd4) && m_en && sum[64]) m_ovf = 1;
        else if (w && a == 3'd1 && d[0]) m_ovf = 0;
        if (c) m_cnt = 0;
        else if (w && a == 3'd4) m_cnt = {m_hipend, d};
        else if (m_en) m_cnt = sum[63:0];
        if (w && a == 3'd2) m_burst = d[23:0];
        else if (m_en && m_burst != 0) m_burst = m_burst - 1;
        if (w && a == 3'd3) m_slow = (d == 0) ? 0 : d - 1;
        else if (m_en && m_ival != 0) m_slow = (m_slow == 0) ? m_ival - 1 : m_slow - 1;
        if (w && a == 3'd3) m_ival = d;
        if (w && a == 3'd5) m_hipend = d;
        if (w && a == 3'd0) begin
            m_en = d[0]; m_base = d[7:4]; m_alt = d[19:8];
        end
    endfunction

    // one clock: drive at negedge, model at edge, compare at next negedge
    task automatic step(string tag, bit w, bit r, logic [2:0] a, logic [31:0] d, bit c);
        reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d; cnt_clear = c;
        @(posedge clk);
        model(w, r, a, d, c);
        @(negedge clk);
        reg_wr = 0; reg_rd = 0; cnt_clear = 0;
        chk64(tag, "time", time_now, m_cnt);
        chk64(tag, "ovf", {63'b0, ovf_flag}, {63'b0, m_ovf});
        if (r) chk64(tag, "rdata", {32'b0, reg_rdata}, {32'b0, m_rdata});
    endtask

    task automatic idle(string tag, int n);
        for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0);
    endtask

    task automatic rd(string tag, logic [2:0] a);
        step(tag, 0, 1, a, 0, 0);
    endtask

    task automatic wr(string tag, logic [2:0] a, logic [31:0] d);
        step(tag, 1, 0, a, d, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_en = 0; m_ovf = 0; m_base = 0; m_alt = 0; m_burst = 0;
        m_ival = 0; m_slow = 0; m_hipend = 0; m_hisnap = 0; m_rdata = 0; m_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk64("R1", "time", time_now, 64'h0);
        chk64("R1", "ovf", {63'b0, ovf_flag}, 64'h0);
        for (int a = 0; a < 7; a++) rd("R1", 3'(a));

        // R2: base increment only
        wr("R2", 3'd0, {12'b0, 12'd9, 4'd5, 3'b0, 1'b1});
        idle("R2", 10);
        rd("R2", 3'd0);

        // R3: halt holds time and trim counters
        wr("R3", 3'd0, {12'b0, 12'd9, 4'd5, 3'b0, 1'b0});
        wr("R3", 3'd2, 32'd6);
        wr("R3", 3'd3, 32'd3);
        idle("R3", 8);
        rd("R3", 3'd2);

        // R4: burst of alternate increments
        wr("R4", 3'd3, 32'd0);
        wr("R4", 3'd0, {12'b0, 12'd9, 4'd5, 3'b0, 1'b1});
        idle("R4", 4);
        rd("R4", 3'd2);
        idle("R4", 4);
        rd("R4", 3'd2);
        wr("R4", 3'd2, 32'd0);
        idle("R4", 2);

        // R5: periodic alternate increment
        wr("R5", 3'd3, 32'd4);
        idle("R5", 12);
        rd("R5", 3'd3);
        wr("R5", 3'd3, 32'd1);
        idle("R5", 3);
        wr("R5", 3'd3, 32'd0);
        idle("R5", 3);

        // R6: time load high then low
        wr("R6", 3'd5, 32'h1234_5678);
        wr("R6", 3'd4, 32'h9abc_def0);
        idle("R6", 2);

        // R7: coherent two-word read
        rd("R7", 3'd4);
        idle("R7", 3);
        rd("R7", 3'd5);

        // R8: wrap past all-ones, W1C
        wr("R8", 3'd5, 32'hffff_ffff);
        wr("R8", 3'd4, 32'hffff_fff0);
        idle("R8", 5);
        rd("R8", 3'd1);
        wr("R8", 3'd1, 32'd0);
        rd("R8", 3'd1);
        wr("R8", 3'd1, 32'd1);
        rd("R8", 3'd1);

        // R9: clear pulse during a burst, priority over load
        wr("R9", 3'd2, 32'd5);
        step("R9", 0, 0, 0, 0, 1);
        rd("R9", 3'd2);
        wr("R9", 3'd5, 32'h0000_0001);
        step("R9", 1, 0, 3'd4, 32'h5555_0000, 1);
        idle("R9", 2);

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            int k;
            logic [2:0]  a;
            logic [31:0] d;
            k = int'($urandom_range(0, 99));
            a = 3'($urandom_range(0, 6));
            d = $urandom;
            if (a == 3'd2) d = d & 32'h1f;
            if (a == 3'd3) d = d & 32'h7;
            if (a == 3'd5 && k < 40) d = 32'hffff_ffff;
            if (a == 3'd0) d[0] = (k < 85);
            if (k < 15)      step("R2", 1, 0, a, d, 0);
            else if (k < 35) step("R7", 0, 1, a, 0, 0);
            else if (k < 37) step("R9", 0, 0, 0, 0, 1);
            else             step("R4", 0, 0, 0, 0, 0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule